// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a timer/counter that only runs as a dual-slope PWM generator. On each enabled tick the counter climbs from zero to a ceiling value, stays there for one tick, then descends back to zero and turns upward again. The ceiling comes either from a directly written period register or from the channel-0 compare value, picked by a configuration pin. Two compare channels turn the counter into waveform pins. Each pin can be turned off, follow the compare result directly, or follow it inverted.

Compare values are written into holding registers. The timer copies them into its working registers only on the tick it spends at zero, so a period's rising and falling halves always use the same ceiling and thresholds. The pulses therefore stay centred even when software reloads them in the middle of a period. Sticky event flags record the zero turn, the ceiling, and each channel's matches. Software reads and clears them through a small word-wide register port.

Top module: `pfc_pwm_timer`

## Requirements
- R1: After synchronous reset the counter reads 0 and counts upward. The period register, both holding registers, both working compare values and all four flags are 0. Both pins are low.
- R2: The counter changes only on a clock edge where `tickEn` is high. With `tickEn` low the counter and flags keep their values, except for flag clears written by software.
- R3: On ticks the count runs 0, 1, … TOP, TOP-1, … 1, 0, 1, …. TOP is held for exactly one tick and a full period spans 2·TOP ticks. If the counter is above TOP while climbing, it turns downward at once. If TOP is 0 the counter stays at 0.
- R4: With `topFromA` = 0, TOP is the period register (address 1), which is not buffered and takes effect immediately. With `topFromA` = 1, TOP is the working compare value of channel 0.
- R5: Writes to the holding registers (address 2 for channel 0, address 3 for channel 1) reach the working compare values only on a tick taken while the counter is 0. That same tick already uses the newly loaded values.
- R6: Flag bit 0 (zero turn) is set by every tick taken while the counter is 0.
- R7: A tick taken at TOP while climbing (counter not 0) sets flag bit 1 when the period register defines TOP, or flag bit 2 when channel 0 defines TOP.
- R8: A tick taken while the counter equals a channel's working compare value sets that channel's flag: bit 2 for channel 0, bit 3 for channel 1.
- R9: A channel whose working compare value is greater than TOP never matches. Its flag stays clear and its pin holds its level.
- R10: Per-channel pin mode: 2 means the pin drops on a match while climbing (ticks at 0 and at TOP count as climbing) and rises on a match while descending. 3 is the opposite. Modes 0 and 1 hold the pin low.
- R11: Flags are sticky and are cleared by writing 1 to their bit at address 4. A flag set on the same edge as its clear stays set.
- R12: Register map: address 0 reads the counter and ignores writes. Address 1 is the period register. Addresses 2 and 3 are the holding registers and read back what was written. Address 4 holds the flags in bits 3:0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Timer tick enable |
| topFromA | input | 1 | 1: channel 0 compare defines TOP; 0: period register does |
| modeA | input | 2 | Pin mode of channel 0 |
| modeB | input | 2 | Pin mode of channel 1 |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data |
| count | output | CNT_W | Current counter value |
| flags | output | 4 | Sticky flags {ch1 match, ch0 match, period TOP, zero turn} |
| pwmA | output | 1 | Waveform pin of channel 0 |
| pwmB | output | 1 | Waveform pin of channel 1 |

## Verification
The bench builds the timer with its default 16-bit counter. It programs ceilings of 4 to 6, so each run covers many complete up/down periods, several zero-turn loads and both ceiling sources in a few hundred cycles. Small ceilings also make it cheap to place a buffered reload in the middle of a period, and to push a compare value above the ceiling so that the no-match case shows at the pins.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

  localparam int CH_N   = 2;
  localparam int FLAG_N = 2 + CH_N;
  localparam int ADDR_W = 3;

  // flag bit positions
  localparam int FL_ZERO = 0;
  localparam int FL_PER  = 1;
  localparam int FL_CH0  = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOLD = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLG  = 3'd4;

  // pin mode codes
  localparam logic [1:0] PM_PLAIN = 2'd2;
  localparam logic [1:0] PM_INV   = 2'd3;

  typedef struct packed {
    logic            bottom;   // tick taken at zero
    logic            topHit;   // tick taken at TOP while climbing
    logic            upDir;    // direction seen by matches on this tick
    logic [CH_N-1:0] hit;      // channel compare matches on this tick
  } pfc_strobe_t;

endpackage

// File: rtl/pfc_pwm_ctrl.sv
module pfc_pwm_ctrl
  import pfc_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tickEn,
  input  logic                       topFromA,
  input  logic [CNT_W-1:0]           perVal,
  input  logic [CH_N-1:0][CNT_W-1:0] holdCmp,
  input  logic [CH_N-1:0][CNT_W-1:0] workCmp,
  output logic [CNT_W-1:0]           count,
  output pfc_strobe_t                strb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, cntD;
  logic             upQ, upD;
  logic             atBottom;
  logic             dirNow;
  logic [CNT_W-1:0] topVal;
  logic [CH_N-1:0][CNT_W-1:0] effCmp;
  logic [CH_N-1:0]  hitVec;

  assign atBottom = (cntQ == '0);
  assign dirNow   = atBottom | upQ;

  // at zero the freshly loaded compare values already apply
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    assign effCmp[ch] = atBottom ? holdCmp[ch] : workCmp[ch];
    assign hitVec[ch] = tickEn && (cntQ == effCmp[ch]) && (effCmp[ch] <= topVal);
  end

  assign topVal = topFromA ? effCmp[0] : perVal;

  always_comb begin
    cntD = cntQ;
    upD  = upQ;
    if (tickEn) begin
      if (atBottom) begin
        cntD = (topVal == '0) ? '0 : ONE;
        upD  = 1'b1;
      end else if (upQ) begin
        if (cntQ >= topVal) begin
          cntD = cntQ - ONE;
          upD  = 1'b0;
        end else begin
          cntD = cntQ + ONE;
        end
      end else begin
        cntD = cntQ - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
      upQ  <= 1'b1;
    end else begin
      cntQ <= cntD;
      upQ  <= upD;
    end
  end

  always_comb begin
    strb.bottom = tickEn && atBottom;
    strb.topHit = tickEn && dirNow && !atBottom && (cntQ == topVal);
    strb.upDir  = dirNow;
    strb.hit    = hitVec;
  end

  assign count = cntQ;

endmodule

// File: rtl/pfc_pwm_dp.sv
module pfc_pwm_dp
  import pfc_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pfc_strobe_t                strb,
  input  logic                       topFromA,
  input  logic [CH_N-1:0][1:0]       chMode,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CNT_W-1:0]           wdata,
  input  logic [CNT_W-1:0]           count,
  output logic [CNT_W-1:0]           rdata,
  output logic [CNT_W-1:0]           perVal,
  output logic [CH_N-1:0][CNT_W-1:0] holdCmp,
  output logic [CH_N-1:0][CNT_W-1:0] workCmp,
  output logic [FLAG_N-1:0]          flagsQ,
  output logic [CH_N-1:0]            pins
);

  logic [FLAG_N-1:0] setVec, clrVec;

  // period register: unbuffered
  always_ff @(posedge clk) begin
    if (rst)                            perVal <= '0;
    else if (wrEn && addr == A_PER)     perVal <= wdata;
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] MY_ADDR = A_HOLD + ADDR_W'(ch);

    always_ff @(posedge clk) begin
      if (rst)                          holdCmp[ch] <= '0;
      else if (wrEn && addr == MY_ADDR) holdCmp[ch] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)              workCmp[ch] <= '0;
      else if (strb.bottom) workCmp[ch] <= holdCmp[ch];
    end

    always_ff @(posedge clk) begin
      if (rst)                         pins[ch] <= 1'b0;
      else if (!chMode[ch][1])         pins[ch] <= 1'b0;
      else if (strb.hit[ch])           pins[ch] <= strb.upDir ? (chMode[ch] == PM_INV)
                                                              : (chMode[ch] == PM_PLAIN);
    end

    if (ch == 0) begin : g_first
      assign setVec[FL_CH0] = strb.hit[0] | (strb.topHit & topFromA);
    end else begin : g_rest
      assign setVec[FL_CH0 + ch] = strb.hit[ch];
    end
  end

  assign setVec[FL_ZERO] = strb.bottom;
  assign setVec[FL_PER]  = strb.topHit & ~topFromA;
  assign clrVec = (wrEn && addr == A_FLG) ? wdata[FLAG_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flagsQ <= '0;
    else     flagsQ <= (flagsQ & ~clrVec) | setVec;
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CNT)      rdata = count;
    else if (addr == A_PER) rdata = perVal;
    else if (addr == A_FLG) rdata = {{(CNT_W-FLAG_N){1'b0}}, flagsQ};
    for (int ch = 0; ch < CH_N; ch++) begin
      if (addr == A_HOLD + ADDR_W'(ch)) rdata = holdCmp[ch];
    end
  end

endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer
  import pfc_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             topFromA,
  input  logic [1:0]       modeA,
  input  logic [1:0]       modeB,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic [3:0]       flags,
  output logic             pwmA,
  output logic             pwmB
);

  pfc_strobe_t                strb;
  logic [CNT_W-1:0]           perVal;
  logic [CH_N-1:0][CNT_W-1:0] holdCmp;
  logic [CH_N-1:0][CNT_W-1:0] workCmp;
  logic [CH_N-1:0][1:0]       chMode;
  logic [CH_N-1:0]            pins;
  logic [FLAG_N-1:0]          flagsQ;

  assign chMode = {modeB, modeA};

  pfc_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .topFromA(topFromA),
    .perVal(perVal), .holdCmp(holdCmp), .workCmp(workCmp),
    .count(count), .strb(strb)
  );

  pfc_pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .topFromA(topFromA), .chMode(chMode),
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .count(count), .rdata(rdata),
    .perVal(perVal), .holdCmp(holdCmp), .workCmp(workCmp),
    .flagsQ(flagsQ), .pins(pins)
  );

  assign flags = flagsQ;
  assign pwmA  = pins[0];
  assign pwmB  = pins[1];

endmodule

// File: rtl/pfc_pwm_checker.sv
module pfc_pwm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic [1:0]       modeA,
  input logic [1:0]       modeB,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       flags,
  input logic             pwmA,
  input logic             pwmB
);

  // R2: no tick, no movement
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(count));

  // R3: each tick moves the counter by one, or leaves it at zero
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> (count == $past(count) + CNT_W'(1)) ||
               (count == $past(count) - CNT_W'(1)) ||
               (count == '0));

  // R6: a tick at zero raises the zero-turn flag
  p_zero_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (tickEn && count == '0) |=> flags[0]);

  // R10: disconnected modes hold the pins low
  p_pin_a_low_r10: assert property (@(posedge clk) disable iff (rst)
    (modeA < 2'd2) |=> !pwmA);

  p_pin_b_low_r10: assert property (@(posedge clk) disable iff (rst)
    (modeB < 2'd2) |=> !pwmB);

endmodule

bind pfc_pwm_timer pfc_pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .modeA(modeA), .modeB(modeB),
  .count(count), .flags(flags), .pwmA(pwmA), .pwmB(pwmB)
);

// File: tb/pfc_pwm_timer_bench.sv
`timescale 1ns/1ps
module pfc_pwm_timer_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tickEn = 1'b0, topFromA = 1'b0, wrEn = 1'b0;
  logic [1:0]   modeA = 2'd0, modeB = 2'd0;
  logic [2:0]   addr = 3'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, count;
  logic [3:0]   flags;
  logic         pwmA, pwmB;

  always #2.5 clk = ~clk;

  pfc_pwm_timer #(.CNT_W(W)) u_pfc_pwm_timer (
    .clk(clk), .rst(rst), .tickEn(tickEn), .topFromA(topFromA),
    .modeA(modeA), .modeB(modeB), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count(count), .flags(flags), .pwmA(pwmA), .pwmB(pwmB)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;

  // configuration driven by step
  logic       bTopA = 1'b0;
  logic [1:0] bModeA = 2'd0, bModeB = 2'd0;

  // reference state
  logic [W-1:0] mCnt, mPer, mHoldA, mHoldB, mWorkA, mWorkB;
  logic         mUp, mPinA, mPinB;
  logic [3:0]   mFlags;

  typedef struct {
    string      tag;
    logic [W-1:0] cnt;
    logic [3:0] fl;
    logic       pa;
    logic       pb;
  } exp_t;

  exp_t q[$];
  exp_t e;

  task automatic mdlReset();
    mCnt = '0; mUp = 1'b1; mPer = '0; mHoldA = '0; mHoldB = '0;
    mWorkA = '0; mWorkB = '0; mPinA = 1'b0; mPinB = 1'b0; mFlags = '0;
  endtask

  function automatic logic [W-1:0] mdlRead(input logic [2:0] ad);
    case (ad)
      3'd0: return mCnt;
      3'd1: return mPer;
      3'd2: return mHoldA;
      3'd3: return mHoldB;
      3'd4: return {12'd0, mFlags};
      default: return '0;
    endcase
  endfunction

  // next state after one edge, built from the requirement list
  task automatic mdl(input bit tk, input bit wr, input logic [2:0] ad, input logic [W-1:0] dt);
    logic [W-1:0] effA, effB, top;
    bit bottom, up, hitA, hitB, topHit;
    logic [3:0] setv, clr;
    setv = '0; hitA = 0; hitB = 0; up = 0;
    if (tk) begin
      bottom = (mCnt == 0);
      effA   = bottom ? mHoldA : mWorkA;
      effB   = bottom ? mHoldB : mWorkB;
      top    = bTopA ? effA : mPer;
      up     = bottom || mUp;
      hitA   = (mCnt == effA) && (effA <= top);
      hitB   = (mCnt == effB) && (effB <= top);
      topHit = up && !bottom && (mCnt == top);
      setv[0] = bottom;
      setv[1] = topHit && !bTopA;
      setv[2] = hitA || (topHit && bTopA);
      setv[3] = hitB;
      if (bottom) begin
        mWorkA = mHoldA; mWorkB = mHoldB;
        mCnt = (top == 0) ? '0 : 16'd1; mUp = 1'b1;
      end else if (mUp) begin
        if (mCnt >= top) begin mCnt = mCnt - 1; mUp = 1'b0; end
        else mCnt = mCnt + 1;
      end else begin
        mCnt = mCnt - 1;
      end
    end
    if (bModeA < 2)  mPinA = 1'b0;
    else if (hitA)   mPinA = up ? (bModeA == 2'd3) : (bModeA == 2'd2);
    if (bModeB < 2)  mPinB = 1'b0;
    else if (hitB)   mPinB = up ? (bModeB == 2'd3) : (bModeB == 2'd2);
    clr = (wr && ad == 3'd4) ? dt[3:0] : 4'd0;
    mFlags = (mFlags & ~clr) | setv;
    if (wr && ad == 3'd1) mPer = dt;
    if (wr && ad == 3'd2) mHoldA = dt;
    if (wr && ad == 3'd3) mHoldB = dt;
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input bit tk, input bit wr, input logic [2:0] ad,
                      input logic [W-1:0] dt, input string tag);
    exp_t x;
    @(negedge clk);
    tickEn = tk; wrEn = wr; addr = ad; wdata = dt;
    topFromA = bTopA; modeA = bModeA; modeB = bModeB;
    mdl(tk, wr, ad, dt);
    x.tag = tag; x.cnt = mCnt; x.fl = mFlags; x.pa = mPinA; x.pb = mPinB;
    q.push_back(x);
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readChk(input logic [2:0] ad, input string req);
    logic [W-1:0] ex;
    ex = mdlRead(ad);
    step(0, 0, ad, '0, req);
    #1;
    chk(rdata === ex, req, rdata, ex);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 3'd0, '0, tag);
  endtask

  // monitor: compare each edge's outcome against the queued expectation
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      nChk++;
      if (count !== e.cnt || flags !== e.fl || pwmA !== e.pa || pwmB !== e.pb) begin
        nFail++;
        $display("FAIL %s: actual cnt=%0d fl=%b a=%b b=%b expected cnt=%0d fl=%b a=%b b=%b",
                 e.tag, count, flags, pwmA, pwmB, e.cnt, e.fl, e.pa, e.pb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  logic savedB;

  initial begin
    mdlReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state through the register port and pins
    for (int a = 0; a < 5; a++) readChk(3'(a), "R1");
    #1; chk(pwmA == 0 && pwmB == 0, "R1", {14'd0, pwmB, pwmA}, '0);

    // R12 / R4: period 5, channel thresholds 2 and 4
    step(0, 1, 3'd1, 16'd5, "R12");
    step(0, 1, 3'd2, 16'd2, "R12");
    step(0, 1, 3'd3, 16'd4, "R12");
    readChk(3'd1, "R12");
    readChk(3'd2, "R12");
    readChk(3'd3, "R12");
    bModeA = 2'd2; bModeB = 2'd3;
    run(32, "R3/R4/R6/R7/R8/R10");

    // R2: ticks every other cycle
    for (int i = 0; i < 20; i++) step(i[0], 0, 3'd0, '0, "R2");

    // R5: reload channel 0 mid-period; readback is immediate, use waits for zero
    run(3, "R5");
    step(0, 1, 3'd2, 16'd3, "R5");
    readChk(3'd2, "R5");
    run(26, "R5/R8/R10");

    // R11: sticky flags, partial and full clear, clears racing with sets
    step(0, 1, 3'd4, 16'h1, "R11");
    readChk(3'd4, "R11");
    step(0, 1, 3'd4, 16'hF, "R11");
    readChk(3'd4, "R11");
    for (int i = 0; i < 12; i++) step(1, 1, 3'd4, 16'hF, "R11");

    // R4 / R7: channel 0 defines TOP
    bTopA = 1'b1;
    step(0, 1, 3'd2, 16'd6, "R4");
    step(0, 1, 3'd3, 16'd3, "R4");
    run(40, "R4/R7/R8");

    // R9: channel 1 threshold above TOP
    bTopA = 1'b0;
    step(0, 1, 3'd1, 16'd4, "R9");
    step(0, 1, 3'd2, 16'd1, "R9");
    step(0, 1, 3'd3, 16'd9, "R9");
    run(12, "R9");
    step(0, 1, 3'd4, 16'hF, "R9");
    #1; savedB = pwmB;
    run(20, "R9");
    #1;
    chk(flags[3] == 1'b0, "R9", {12'd0, flags}, {12'd0, flags & 4'h7});
    chk(pwmB == savedB, "R9", {15'd0, pwmB}, {15'd0, savedB});

    // R10: modes 0 and 1 hold pins low
    bModeA = 2'd0; bModeB = 2'd1;
    run(10, "R10");
    #1; chk(pwmA == 0 && pwmB == 0, "R10", {14'd0, pwmB, pwmA}, '0);

    // R12: counter is read-only
    step(0, 1, 3'd0, 16'h55, "R12");
    readChk(3'd0, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule